// File: doc/BRIEF.md
# 64-Source Interrupt Controller Register Block

This block gathers 64 interrupt inputs into two request lines for a processor: a normal request and a fast request. Software sets up each source through a small memory-mapped register file. Each source can be set as level-sensitive or edge-sensitive, with an active level or edge direction. Each source can be enabled, routed to either request line, and raised by software.

The 64 sources are held as two 32-bit banks. Every register has a low-bank word and a high-bank word, placed 4 bytes apart. The enable and software-raise bits each have a set address and a separate clear address, both write-one. An edge that is caught stays latched until software clears it. Three status views show pending sources: before masking, and after masking split by routing.

The bus has a write port and a separate, combinational read port. A write commits on the rising clock edge. A read returns data in the same cycle as its address.

Top module: `intc64_regs`

## Requirements
- R1: Source n lives in bank n>>5 at bit n&31. Each register's low-bank word is at its base offset and its high-bank word at base+4. Address bits [1:0] are ignored. Read data follows the read address in the same cycle.
- R2: The base offsets are:
  - status: normal-routed 0x00, fast-routed 0x08, unmasked 0x10, edge latches 0x60
  - route select 0x18
  - enable set 0x20, enable clear 0x28
  - software raise set 0x30, software raise clear 0x38
  - mode 0x40, both-edges 0x48, polarity 0x50
  - latch clear 0x58
- R3: Writing a one to an enable-set bit enables that source. Writing a one to an enable-clear bit disables it. Zero bits leave their sources unchanged. Both addresses read back the current enable bits.
- R4: The software raise bits work the same way through their set and clear addresses, and both addresses read them back. A raised source is pending whatever its input and mode.
- R5: Route bit 0 sends an enabled, pending source to the normal line. Route bit 1 sends it to the fast line.
- R6: Mode bit 1 makes a source level-sensitive, and mode bit 0 makes it edge-sensitive. Polarity bit 1 selects active-high level or rising edge; bit 0 selects active-low level or falling edge. A level source is pending while its input equals its polarity bit. Mode and polarity are read/write.
- R7: An edge source latches the edge on the clock edge after it is seen at the input. The latch holds until a one is written to that source's latch-clear bit. If a new edge and a clear come in the same cycle, the new edge wins. Edges of the wrong direction are ignored. Latch-clear writes do not affect level sources.
- R8: When a source's both-edges bit is 1, rising and falling edges both set its latch.
- R9: Unmasked status is the pending set. Normal status is pending AND enabled AND route 0. Fast status is pending AND enabled AND route 1.
- R10: irq_req is the OR of both normal-status words, and fiq_req is the OR of both fast-status words. Both are combinational from the status.
- R11: Synchronous reset clears these to zero: enables, raise bits, routes, both-edges bits, latches and edge history. Mode loads SENSE_RST, and polarity loads EVENT_RST (all ones by default).
- R12: Writes to status addresses or to addresses at or above 0x68 change nothing. Latch-clear addresses and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Write strobe |
| bus_waddr | input | 8 | Write byte address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 8 | Read byte address |
| bus_rdata | output | 32 | Read data, combinational |
| src_in | input | 64 | Raw interrupt inputs |
| irq_req | output | 1 | Normal interrupt request |
| fiq_req | output | 1 | Fast interrupt request |

## Verification
The bench targets the following corner cases, and each would expose a specific mistake:
- **Latch held after the input falls.** A latch that followed the input would drop the request too early.
- **Clear with the input still high.** A detector that mistook a steady high for an edge would re-arm the latch.
- **Wrong-direction edge.** With both-edges off, a falling edge must be ignored; with it on, the same edge must set the latch.
- **Edge and clear in the same cycle.** A clear-first priority would lose the new event.
- **Zero bits in set and clear writes.** A plain register write in place of set/clear logic would wipe the neighbouring enables.
- **Latch clear on a level source.** Touching a level source this way must not drop its request.
- **High-bank routing on source 63.** This catches the wrong half being picked.
- **Writes to status and unmapped addresses.** Any state change from these writes is caught.

// File: rtl/intc64_pkg.sv
package intc64_pkg;

    localparam int BANK_W    = 32;
    localparam int NUM_BANKS = 2;
    localparam int NUM_SRC   = BANK_W * NUM_BANKS;
    localparam int ADDR_W    = 8;
    localparam int RID_W     = 5;

    // Register identifiers: byte offset = id*8 + bank*4
    typedef enum logic [RID_W-1:0] {
        REG_IRQ_ST    = 5'd0,
        REG_FIQ_ST    = 5'd1,
        REG_RAW_ST    = 5'd2,
        REG_ROUTE     = 5'd3,
        REG_EN_SET    = 5'd4,
        REG_EN_CLR    = 5'd5,
        REG_TRG_SET   = 5'd6,
        REG_TRG_CLR   = 5'd7,
        REG_MODE      = 5'd8,
        REG_BOTH      = 5'd9,
        REG_POL       = 5'd10,
        REG_LATCH_CLR = 5'd11,
        REG_LATCH_ST  = 5'd12
    } reg_id_e;

    // Per-bank write strobes
    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic trg_set;
        logic trg_clr;
        logic route_wr;
        logic mode_wr;
        logic both_wr;
        logic pol_wr;
        logic latch_clr;
    } bank_wr_t;

    // Per-bank state and status seen by the read path
    typedef struct packed {
        logic [BANK_W-1:0] raw;
        logic [BANK_W-1:0] irq_st;
        logic [BANK_W-1:0] fiq_st;
        logic [BANK_W-1:0] en;
        logic [BANK_W-1:0] trg;
        logic [BANK_W-1:0] route;
        logic [BANK_W-1:0] mode;
        logic [BANK_W-1:0] both;
        logic [BANK_W-1:0] pol;
        logic [BANK_W-1:0] latch;
    } bank_view_t;

    function automatic logic [RID_W-1:0] addr_rid(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:3];
    endfunction

    function automatic logic addr_bank(input logic [ADDR_W-1:0] a);
        return a[2];
    endfunction

    // Masked update used by the set/clear register pairs
    function automatic logic [BANK_W-1:0] set_clr(
        input logic [BANK_W-1:0] cur,
        input logic              do_set,
        input logic              do_clr,
        input logic [BANK_W-1:0] mask
    );
        logic [BANK_W-1:0] nxt;
        nxt = cur;
        if (do_set) nxt = nxt | mask;
        if (do_clr) nxt = nxt & ~mask;
        return nxt;
    endfunction

endpackage

// File: rtl/intc64_wr_decode.sv
module intc64_wr_decode
    import intc64_pkg::*;
(
    input  logic                             wen,
    input  logic [ADDR_W-1:0]                waddr,
    output bank_wr_t [NUM_BANKS-1:0]         strb
);

    logic [RID_W-1:0] rid;
    logic             bsel;

    assign rid  = addr_rid(waddr);
    assign bsel = addr_bank(waddr);

    always_comb begin
        strb = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (wen && (bsel == 1'(b))) begin
                case (reg_id_e'(rid))
                    REG_EN_SET:    strb[b].en_set    = 1'b1;
                    REG_EN_CLR:    strb[b].en_clr    = 1'b1;
                    REG_TRG_SET:   strb[b].trg_set   = 1'b1;
                    REG_TRG_CLR:   strb[b].trg_clr   = 1'b1;
                    REG_ROUTE:     strb[b].route_wr  = 1'b1;
                    REG_MODE:      strb[b].mode_wr   = 1'b1;
                    REG_BOTH:      strb[b].both_wr   = 1'b1;
                    REG_POL:       strb[b].pol_wr    = 1'b1;
                    REG_LATCH_CLR: strb[b].latch_clr = 1'b1;
                    default:       ; // status and unmapped: no write (R12)
                endcase
            end
        end
    end

endmodule

// File: rtl/intc64_bank.sv
module intc64_bank
    import intc64_pkg::*;
#(
    parameter logic [BANK_W-1:0] MODE_RST = '0,
    parameter logic [BANK_W-1:0] POL_RST  = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] src_in,
    input  bank_wr_t          strb,
    input  logic [BANK_W-1:0] wdata,
    output bank_view_t        view
);

    logic [BANK_W-1:0] en_q, trg_q, route_q, mode_q, both_q, pol_q;
    logic [BANK_W-1:0] latch_q, hist_q;

    logic [BANK_W-1:0] rise, fall, hit, edge_src, clr_mask;
    logic [BANK_W-1:0] latch_d, level_act, pend;

    // Edge detection against the previous sample
    assign rise      = src_in & ~hist_q;
    assign fall      = ~src_in & hist_q;
    assign hit       = (both_q & (rise | fall))
                     | (~both_q & ((pol_q & rise) | (~pol_q & fall)));
    assign edge_src  = ~mode_q;
    assign clr_mask  = strb.latch_clr ? wdata : '0;

    // New edge wins over a coincident clear; level sources keep no latch
    assign latch_d   = edge_src & (hit | (latch_q & ~clr_mask));

    assign level_act = mode_q & ~(src_in ^ pol_q);
    assign pend      = level_act | (edge_src & latch_q) | trg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            trg_q   <= '0;
            route_q <= '0;
            mode_q  <= MODE_RST;
            both_q  <= '0;
            pol_q   <= POL_RST;
            latch_q <= '0;
            hist_q  <= '0;
        end else begin
            en_q    <= set_clr(en_q,  strb.en_set,  strb.en_clr,  wdata);
            trg_q   <= set_clr(trg_q, strb.trg_set, strb.trg_clr, wdata);
            if (strb.route_wr) route_q <= wdata;
            if (strb.mode_wr)  mode_q  <= wdata;
            if (strb.both_wr)  both_q  <= wdata;
            if (strb.pol_wr)   pol_q   <= wdata;
            latch_q <= latch_d;
            hist_q  <= src_in;
        end
    end

    always_comb begin
        view.raw    = pend;
        view.irq_st = pend & en_q & ~route_q;
        view.fiq_st = pend & en_q &  route_q;
        view.en     = en_q;
        view.trg    = trg_q;
        view.route  = route_q;
        view.mode   = mode_q;
        view.both   = both_q;
        view.pol    = pol_q;
        view.latch  = latch_q;
    end

endmodule

// File: rtl/intc64_rd_mux.sv
module intc64_rd_mux
    import intc64_pkg::*;
(
    input  logic [ADDR_W-1:0]          raddr,
    input  bank_view_t [NUM_BANKS-1:0] views,
    output logic [BANK_W-1:0]          rdata
);

    bank_view_t v;

    assign v = views[addr_bank(raddr)];

    always_comb begin
        case (reg_id_e'(addr_rid(raddr)))
            REG_IRQ_ST:                rdata = v.irq_st;
            REG_FIQ_ST:                rdata = v.fiq_st;
            REG_RAW_ST:                rdata = v.raw;
            REG_ROUTE:                 rdata = v.route;
            REG_EN_SET, REG_EN_CLR:    rdata = v.en;
            REG_TRG_SET, REG_TRG_CLR:  rdata = v.trg;
            REG_MODE:                  rdata = v.mode;
            REG_BOTH:                  rdata = v.both;
            REG_POL:                   rdata = v.pol;
            REG_LATCH_ST:              rdata = v.latch;
            default:                   rdata = '0;
        endcase
    end

endmodule

// File: rtl/intc64_regs.sv
module intc64_regs
    import intc64_pkg::*;
#(
    parameter logic [NUM_SRC-1:0] SENSE_RST = 64'h0000_0000_0000_000F,
    parameter logic [NUM_SRC-1:0] EVENT_RST = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wen,
    input  logic [ADDR_W-1:0]  bus_waddr,
    input  logic [BANK_W-1:0]  bus_wdata,
    input  logic [ADDR_W-1:0]  bus_raddr,
    output logic [BANK_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               irq_req,
    output logic               fiq_req
);

    bank_wr_t   [NUM_BANKS-1:0] strb;
    bank_view_t [NUM_BANKS-1:0] views;

    logic [NUM_SRC-1:0] irq_all, fiq_all, en_all, trg_all, latch_all;

    intc64_wr_decode u_wr_decode (
        .wen   (bus_wen),
        .waddr (bus_waddr),
        .strb  (strb)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        intc64_bank #(
            .MODE_RST (SENSE_RST[b*BANK_W +: BANK_W]),
            .POL_RST  (EVENT_RST[b*BANK_W +: BANK_W])
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .src_in (src_in[b*BANK_W +: BANK_W]),
            .strb   (strb[b]),
            .wdata  (bus_wdata),
            .view   (views[b])
        );

        assign irq_all  [b*BANK_W +: BANK_W] = views[b].irq_st;
        assign fiq_all  [b*BANK_W +: BANK_W] = views[b].fiq_st;
        assign en_all   [b*BANK_W +: BANK_W] = views[b].en;
        assign trg_all  [b*BANK_W +: BANK_W] = views[b].trg;
        assign latch_all[b*BANK_W +: BANK_W] = views[b].latch;
    end

    intc64_rd_mux u_rd_mux (
        .raddr (bus_raddr),
        .views (views),
        .rdata (bus_rdata)
    );

    assign irq_req = |irq_all;
    assign fiq_req = |fiq_all;

endmodule

// File: rtl/intc64_regs_chk.sv
module intc64_regs_chk
    import intc64_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_wen,
    input logic [ADDR_W-1:0]  bus_waddr,
    input logic [BANK_W-1:0]  bus_wdata,
    input logic               irq_req,
    input logic               fiq_req,
    input logic [NUM_SRC-1:0] en_all,
    input logic [NUM_SRC-1:0] trg_all,
    input logic [NUM_SRC-1:0] latch_all
);

    AST_EN_SET_LO: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_waddr == 8'h20) |=>
        ((en_all[31:0] & $past(bus_wdata)) == $past(bus_wdata)));   // R3

    AST_EN_CLR_HI: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_waddr == 8'h2C) |=>
        ((en_all[63:32] & $past(bus_wdata)) == '0));                 // R3

    AST_TRG_SET_HI: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_waddr == 8'h34) |=>
        ((trg_all[63:32] & $past(bus_wdata)) == $past(bus_wdata)));  // R4

    AST_TRG_CLR_LO: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_waddr == 8'h38) |=>
        ((trg_all[31:0] & $past(bus_wdata)) == '0));                 // R4

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_wen |=> ((latch_all & $past(latch_all)) == $past(latch_all))); // R7

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (en_all == '0) |-> (!irq_req && !fiq_req));                   // R9

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_all == '0 && trg_all == '0 && latch_all == '0)); // R11

endmodule

bind intc64_regs intc64_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wen   (bus_wen),
    .bus_waddr (bus_waddr),
    .bus_wdata (bus_wdata),
    .irq_req   (irq_req),
    .fiq_req   (fiq_req),
    .en_all    (en_all),
    .trg_all   (trg_all),
    .latch_all (latch_all)
);

// File: tb/intc64_regs_tb.sv
`timescale 1ns/100ps
module intc64_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  bus_raddr = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src = '0;
    logic        irq_req, fiq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        bit          pin;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    intc64_regs u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wen   (bus_wen),
        .bus_waddr (bus_waddr),
        .bus_wdata (bus_wdata),
        .bus_raddr (bus_raddr),
        .bus_rdata (bus_rdata),
        .src_in    (src),
        .irq_req   (irq_req),
        .fiq_req   (fiq_req)
    );

    // Driver-side helpers: queue expected results
    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
        item_t it;
        it.pin = 0; it.addr = a; it.exp = e; it.req = r;
        sb_q.push_back(it);
    endtask

    task automatic pins(input logic [1:0] e, input string r);  // {fiq_req, irq_req}
        item_t it;
        it.pin = 1; it.addr = '0; it.exp = {30'b0, e}; it.req = r;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_waddr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expected items and compares against the ports
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] got;
        #2;
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            if (it.pin) begin
                got = {30'b0, fiq_req, irq_req};
            end else begin
                bus_raddr = it.addr;
                #0.1;
                got = bus_rdata;
            end
            checks++;
            if (got !== it.exp) begin
                fails++;
                $display("FAIL %s addr=%h actual=%h expected=%h",
                         it.req, it.addr, got, it.exp);
            end
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        // Reset state (R11)
        rd(8'h20, 32'h0, "R11 enables");
        rd(8'h40, 32'hF, "R11 mode low");
        rd(8'h44, 32'h0, "R11 mode high");
        rd(8'h50, 32'hFFFF_FFFF, "R11 polarity");
        rd(8'h18, 32'h0, "R11 route");
        pins(2'b00, "R11 pins");

        // Level source 1, unmasked view before enable (R6, R9)
        @(negedge clk); src[1] = 1'b1;
        rd(8'h10, 32'h2, "R9 raw before mask");
        rd(8'h00, 32'h0, "R9 masked");
        pins(2'b00, "R10 masked pins");
        wr(8'h20, 32'h2);
        rd(8'h00, 32'h2, "R6 level pending");
        rd(8'h28, 32'h2, "R3 clear addr readback");
        pins(2'b01, "R10 irq line");

        // Zero bits leave others alone (R3)
        wr(8'h20, 32'h8);
        rd(8'h20, 32'hA, "R3 set keeps others");
        wr(8'h28, 32'h8);
        rd(8'h20, 32'h2, "R3 clear keeps others");

        // Routing (R5)
        wr(8'h18, 32'h2);
        rd(8'h00, 32'h0, "R5 not on irq");
        rd(8'h08, 32'h2, "R5 fiq status");
        pins(2'b10, "R5 fiq line");
        wr(8'h18, 32'h0);

        // Latch clear on a level source (R7)
        wr(8'h58, 32'h2);
        rd(8'h00, 32'h2, "R7 level unaffected by clear");
        pins(2'b01, "R7 level line");
        @(negedge clk); src[1] = 1'b0;
        rd(8'h10, 32'h0, "R6 level drops");
        pins(2'b00, "R6 line drops");

        // Polarity (R6)
        wr(8'h50, 32'hFFFF_FFFD);
        rd(8'h10, 32'h2, "R6 active low");
        wr(8'h50, 32'hFFFF_FFFF);

        // Edge source 40 = bank 1 bit 8 (R1, R7)
        wr(8'h24, 32'h100);
        @(negedge clk); src[40] = 1'b1;
        rd(8'h14, 32'h0, "R7 not latched yet");
        tick(1);
        rd(8'h14, 32'h100, "R7 latched");
        rd(8'h64, 32'h100, "R7 latch status");
        rd(8'h04, 32'h100, "R1 high bank irq status");
        pins(2'b01, "R10 edge line");
        @(negedge clk); src[40] = 1'b0;
        tick(2);
        rd(8'h64, 32'h100, "R7 held after input falls");
        wr(8'h5C, 32'h100);
        rd(8'h64, 32'h0, "R7 cleared");
        pins(2'b00, "R7 line after clear");
        @(negedge clk); src[40] = 1'b1;
        tick(1);
        wr(8'h5C, 32'h100);
        rd(8'h64, 32'h0, "R7 steady high no rearm");
        @(negedge clk); src[40] = 1'b0;
        tick(1);
        rd(8'h64, 32'h0, "R7 falling ignored");

        // Both edges (R8)
        wr(8'h4C, 32'h100);
        rd(8'h4C, 32'h100, "R2 both-edges readback");
        @(negedge clk); src[40] = 1'b1;
        tick(1);
        rd(8'h64, 32'h100, "R8 rising");
        wr(8'h5C, 32'h100);
        @(negedge clk); src[40] = 1'b0;
        tick(1);
        rd(8'h64, 32'h100, "R8 falling");
        wr(8'h5C, 32'h100);
        rd(8'h64, 32'h0, "R8 cleared");

        // New edge beats coincident clear (R7)
        @(negedge clk);
        src[40] = 1'b1;
        bus_waddr = 8'h5C; bus_wdata = 32'h100; bus_wen = 1'b1;
        @(negedge clk); bus_wen = 1'b0;
        rd(8'h64, 32'h100, "R7 edge wins over clear");
        wr(8'h5C, 32'h100);

        // Software raise (R4)
        wr(8'h30, 32'h20);
        rd(8'h10, 32'h20, "R4 raise pending");
        rd(8'h30, 32'h20, "R4 set readback");
        rd(8'h38, 32'h20, "R4 clear readback");
        rd(8'h00, 32'h0, "R4 masked");
        pins(2'b00, "R4 masked line");
        wr(8'h20, 32'h20);
        rd(8'h00, 32'h20, "R4 enabled");
        pins(2'b01, "R4 line");
        wr(8'h38, 32'h20);
        rd(8'h10, 32'h0, "R4 removed");
        pins(2'b00, "R4 line removed");

        // Source 63 on the fast line (R1, R5)
        wr(8'h1C, 32'h8000_0000);
        wr(8'h34, 32'h8000_0000);
        rd(8'h14, 32'h8000_0000, "R1 source 63 raw");
        rd(8'h0C, 32'h0, "R5 fast masked");
        wr(8'h24, 32'h8000_0000);
        rd(8'h0C, 32'h8000_0000, "R5 fast high status");
        rd(8'h04, 32'h0, "R5 not on irq high");
        pins(2'b10, "R10 fiq line");

        // Ignored writes and zero reads (R12)
        wr(8'h0C, 32'h0);
        rd(8'h0C, 32'h8000_0000, "R12 status write ignored");
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h20, 32'h22, "R12 unmapped write low");
        rd(8'h24, 32'h8000_0100, "R12 unmapped write high");
        rd(8'h80, 32'h0, "R12 unmapped read");
        rd(8'h58, 32'h0, "R12 clear addr reads zero");

        // Reset mid-run (R11)
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        rd(8'h24, 32'h0, "R11 enables cleared");
        rd(8'h34, 32'h0, "R11 raise cleared");
        rd(8'h1C, 32'h0, "R11 route cleared");
        rd(8'h4C, 32'h0, "R11 both cleared");
        pins(2'b00, "R11 lines quiet");
        @(negedge clk); rst = 1'b0;
        tick(2);
        done = 1;
        summary();
        $finish;
    end

endmodule